// File: doc/BRIEF.md
# Maskable Interrupt Acceptance Sequencer

This block is the front end of a processor core that decides when a maskable interrupt is taken. It keeps a pending-flag register, an enable register and a global mask bit. A request line sets its flag. While the sequencer is idle and the global mask is clear, the lowest-numbered line that is both pending and enabled is selected. The block then walks a fixed entry sequence. It clears the selected flag, saves the enable register and the mask into a single-entry context store, presents the vector index with an acknowledge, and finally clears the taken line's enable bit and raises the global mask.

Handler software uses the write inputs to change enables and to set or clear the mask. If it re-enables lines and clears the mask, a second interrupt can nest. That entry overwrites the saved context with the values in force inside the first handler. A return pulse loads the saved enable register and mask back into the live registers. Register writes, flag clears and returns are only accepted while the sequencer is idle.

The sequencer has five states: `ST_IDLE`, `ST_CLEAR`, `ST_SAVE`, `ST_FETCH` and `ST_MASK`. Its transitions are:
- take (`ST_IDLE` to `ST_CLEAR`, when a pending enabled line exists and the mask is clear)
- wait (`ST_IDLE` to itself)
- clear-done (`ST_CLEAR` to `ST_SAVE`)
- save-done (`ST_SAVE` to `ST_FETCH`)
- fetch-done (`ST_FETCH` to `ST_MASK`)
- lock-done (`ST_MASK` to `ST_IDLE`)

Top module: `irq_accept_seq`

## Requirements
- R1: A one-cycle pulse on a bit of `irq_req` sets the matching bit of `flag_q` at the next clock edge. The bit stays set until the line is accepted or software clears it.
- R2: No entry starts while `gmask_q` is 1, and none starts for a pending line whose `enable_q` bit is 0. Such a flag stays pending.
- R3: When several lines are pending and enabled, the lowest-numbered one is taken. `vec_idx` carries its number (bit k of the registers is line k) while `ack` is high.
- R4: An entry starts one clock after the take condition is seen in idle. `busy` is then high for exactly four cycles. The taken flag bit is cleared at the end of the first busy cycle. `ack` is high only in the third busy cycle.
- R5: At the end of an entry, the taken line's `enable_q` bit is 0, all other enable bits are unchanged and `gmask_q` is 1.
- R6: A `ret_req` pulse while idle loads `enable_q` and `gmask_q` with the values that were held when the most recent entry saved its context.
- R7: Inside a handler, software can set enable bits and clear the mask to let a second interrupt nest. That entry saves the handler-time enable register and mask, and a later return restores those values.
- R8: While `busy` is high, `en_wr_en`, `mask_set`, `mask_clr`, `ret_req` and `flag_clr_en` have no effect.
- R9: A request arriving in the same cycle that its flag is cleared, whether by the sequencer or by software, leaves the flag set.
- R10: After reset, `flag_q` and `enable_q` are 0, `gmask_q` is 1, and `busy` and `ack` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | LINES | Request pulses, one per line |
| flag_clr_en | input | 1 | Software flag-clear strobe |
| flag_clr_mask | input | LINES | Flags to clear, where a bit is 1 |
| en_wr_en | input | 1 | Enable-register write strobe |
| en_wr_data | input | LINES | New enable-register value |
| mask_set | input | 1 | Raise the global mask (wins over `mask_clr`) |
| mask_clr | input | 1 | Lower the global mask |
| ret_req | input | 1 | Return from handler: restore saved context |
| flag_q | output | LINES | Pending-flag register |
| enable_q | output | LINES | Enable register |
| gmask_q | output | 1 | Global mask, 1 blocks all entries |
| busy | output | 1 | Entry sequence in progress |
| ack | output | 1 | Vector-fetch cycle, `vec_idx` valid |
| vec_idx | output | $clog2(LINES) | Number of the line being taken |

## Verification
The hardest situation to reach from the ports is a nested entry. It needs a handler context in which the mask is already set and the taken line is disabled, followed by software re-enabling a line and lowering the mask so that a second entry overwrites the saved context. The stimulus gets there by first completing an entry that starts with the mask clear. It then writes the enable register and lowers the mask from idle, checks the second acknowledge, and returns to confirm that the handler-time values come back. A request timed to land on the sequencer's clear edge, and writes issued mid-sequence, are placed by counting falling edges from the mask release.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CLEAR = 3'd1,
        ST_SAVE  = 3'd2,
        ST_FETCH = 3'd3,
        ST_MASK  = 3'd4
    } seq_state_e;

    localparam int ENTRY_CYCLES = 4;

endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int LINES = 16,
    parameter int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] set_vec,
    input  logic [LINES-1:0] sw_clr_vec,
    input  logic             hw_clr_en,
    input  logic [IDX_W-1:0] hw_clr_idx,
    output logic [LINES-1:0] flags
);

    logic [LINES-1:0] hw_clr_vec;
    logic [LINES-1:0] clr_vec;
    logic [LINES-1:0] flags_nxt;

    // one-hot decode of the sequencer clear, one comparator per line
    generate
        for (genvar g = 0; g < LINES; g++) begin : g_dec
            assign hw_clr_vec[g] = hw_clr_en && (hw_clr_idx == IDX_W'(g));
        end
    endgenerate

    always_comb begin
        clr_vec   = hw_clr_vec | sw_clr_vec;
        // a new request wins over any clear in the same cycle
        flags_nxt = (flags & ~clr_vec) | set_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            flags <= flags_nxt;
        end
    end

endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
    parameter int LINES = 16,
    parameter int IDX_W = $clog2(LINES)
) (
    input  logic [LINES-1:0] pend,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        any = |pend;
        idx = '0;
        // scan downwards so the lowest pending line is written last
        for (int i = LINES - 1; i >= 0; i--) begin
            if (pend[i]) begin
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/irq_ctx_store.sv
module irq_ctx_store #(
    parameter int LINES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             save_en,
    input  logic [LINES-1:0] en_in,
    input  logic             mask_in,
    output logic [LINES-1:0] en_saved,
    output logic             mask_saved
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_saved   <= '0;
            mask_saved <= 1'b1;
        end else if (save_en) begin
            en_saved   <= en_in;
            mask_saved <= mask_in;
        end
    end

endmodule

// File: rtl/irq_seq_ctrl.sv
module irq_seq_ctrl
    import irq_seq_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic [IDX_W-1:0] take_idx,
    output logic [IDX_W-1:0] sel_idx,
    output logic             busy,
    output logic             ack,
    output logic             clr_flag,
    output logic             save_ctx,
    output logic             lock
);

    seq_state_e state_q;
    seq_state_e state_nxt;

    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_IDLE:  state_nxt = take ? ST_CLEAR : ST_IDLE;
            ST_CLEAR: state_nxt = ST_SAVE;
            ST_SAVE:  state_nxt = ST_FETCH;
            ST_FETCH: state_nxt = ST_MASK;
            ST_MASK:  state_nxt = ST_IDLE;
            default:  state_nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nxt;
        end
    end

    // selected line is frozen for the whole entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_idx <= '0;
        end else if (state_q == ST_IDLE && take) begin
            sel_idx <= take_idx;
        end
    end

    // outputs
    always_comb begin
        busy     = 1'b1;
        ack      = 1'b0;
        clr_flag = 1'b0;
        save_ctx = 1'b0;
        lock     = 1'b0;
        unique case (state_q)
            ST_IDLE:  busy     = 1'b0;
            ST_CLEAR: clr_flag = 1'b1;
            ST_SAVE:  save_ctx = 1'b1;
            ST_FETCH: ack      = 1'b1;
            ST_MASK:  lock     = 1'b1;
            default:  busy     = 1'b0;
        endcase
    end

endmodule

// File: rtl/irq_accept_seq.sv
module irq_accept_seq
    import irq_seq_pkg::*;
#(
    parameter  int LINES = 16,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] irq_req,
    input  logic             flag_clr_en,
    input  logic [LINES-1:0] flag_clr_mask,
    input  logic             en_wr_en,
    input  logic [LINES-1:0] en_wr_data,
    input  logic             mask_set,
    input  logic             mask_clr,
    input  logic             ret_req,
    output logic [LINES-1:0] flag_q,
    output logic [LINES-1:0] enable_q,
    output logic             gmask_q,
    output logic             busy,
    output logic             ack,
    output logic [IDX_W-1:0] vec_idx
);

    logic [LINES-1:0] pend;
    logic             pend_any;
    logic [IDX_W-1:0] pend_idx;
    logic [IDX_W-1:0] sel_idx;
    logic             clr_flag;
    logic             save_ctx;
    logic             lock;
    logic             idle;
    logic [LINES-1:0] sw_clr_vec;
    logic [LINES-1:0] en_saved;
    logic             mask_saved;
    logic [LINES-1:0] sel_onehot;

    assign idle       = !busy;
    assign pend       = flag_q & enable_q;
    assign sw_clr_vec = (idle && flag_clr_en) ? flag_clr_mask : '0;
    assign sel_onehot = LINES'(1) << sel_idx;
    assign vec_idx    = sel_idx;

    irq_flag_bank #(.LINES(LINES), .IDX_W(IDX_W)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_vec    (irq_req),
        .sw_clr_vec (sw_clr_vec),
        .hw_clr_en  (clr_flag),
        .hw_clr_idx (sel_idx),
        .flags      (flag_q)
    );

    irq_pick #(.LINES(LINES), .IDX_W(IDX_W)) u_pick (
        .pend (pend),
        .any  (pend_any),
        .idx  (pend_idx)
    );

    irq_seq_ctrl #(.IDX_W(IDX_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (pend_any && !gmask_q),
        .take_idx (pend_idx),
        .sel_idx  (sel_idx),
        .busy     (busy),
        .ack      (ack),
        .clr_flag (clr_flag),
        .save_ctx (save_ctx),
        .lock     (lock)
    );

    irq_ctx_store #(.LINES(LINES)) u_ctx (
        .clk        (clk),
        .rst_n      (rst_n),
        .save_en    (save_ctx),
        .en_in      (enable_q),
        .mask_in    (gmask_q),
        .en_saved   (en_saved),
        .mask_saved (mask_saved)
    );

    // enable register: entry lock, then return, then software write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_q <= '0;
        end else if (lock) begin
            enable_q <= enable_q & ~sel_onehot;
        end else if (idle && ret_req) begin
            enable_q <= en_saved;
        end else if (idle && en_wr_en) begin
            enable_q <= en_wr_data;
        end
    end

    // global mask: entry lock, then return, then set over clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gmask_q <= 1'b1;
        end else if (lock) begin
            gmask_q <= 1'b1;
        end else if (idle && ret_req) begin
            gmask_q <= mask_saved;
        end else if (idle && mask_set) begin
            gmask_q <= 1'b1;
        end else if (idle && mask_clr) begin
            gmask_q <= 1'b0;
        end
    end

endmodule

// File: rtl/irq_accept_seq_chk.sv
module irq_accept_seq_chk #(
    parameter int LINES = 16,
    parameter int IDX_W = $clog2(LINES)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LINES-1:0] enable_q,
    input logic             gmask_q,
    input logic             busy,
    input logic             ack,
    input logic [IDX_W-1:0] vec_idx
);

    AST_ENTRY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> busy ##1 busy ##1 busy ##1 !busy); // R4

    AST_ACK_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ##2 ack); // R4

    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack); // R4

    AST_TAKE_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !$past(gmask_q)); // R2

    AST_EXIT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> gmask_q); // R5

    AST_EXIT_LINE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !enable_q[$past(vec_idx)]); // R5

    AST_BUSY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> $stable(enable_q) && $stable(gmask_q)); // R8

endmodule

bind irq_accept_seq irq_accept_seq_chk #(.LINES(LINES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable_q (enable_q),
    .gmask_q  (gmask_q),
    .busy     (busy),
    .ack      (ack),
    .vec_idx  (vec_idx)
);

// File: tb/test_irq_accept_seq.sv
`timescale 1ns/1ps
module test_irq_accept_seq;

    localparam int LINES = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [LINES-1:0] irq_req = '0;
    logic             flag_clr_en = 1'b0;
    logic [LINES-1:0] flag_clr_mask = '0;
    logic             en_wr_en = 1'b0;
    logic [LINES-1:0] en_wr_data = '0;
    logic             mask_set = 1'b0;
    logic             mask_clr = 1'b0;
    logic             ret_req = 1'b0;
    logic [LINES-1:0] flag_q;
    logic [LINES-1:0] enable_q;
    logic             gmask_q;
    logic             busy;
    logic             ack;
    logic [3:0]       vec_idx;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    irq_accept_seq #(.LINES(LINES)) i_irq_accept_seq (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req),
        .flag_clr_en(flag_clr_en), .flag_clr_mask(flag_clr_mask),
        .en_wr_en(en_wr_en), .en_wr_data(en_wr_data),
        .mask_set(mask_set), .mask_clr(mask_clr), .ret_req(ret_req),
        .flag_q(flag_q), .enable_q(enable_q), .gmask_q(gmask_q),
        .busy(busy), .ack(ack), .vec_idx(vec_idx)
    );

    // {enable[15:0], request[15:0], expected line[3:0]}
    localparam logic [35:0] TBL [0:4] = '{
        36'hFFFF_0001_0,
        36'hFFFF_8000_F,
        36'hFFFF_0A40_6,
        36'h0FF0_0F0F_8,
        36'h8001_8000_F
    };

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 5000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] en;
        logic [15:0] rq;
        logic [3:0]  vx;
        logic [15:0] bit1;
        int          busy_seen;

        tick(); tick();
        // R10 reset state
        chk("R10 flag", 32'(flag_q), 32'h0);
        chk("R10 enable", 32'(enable_q), 32'h0);
        chk("R10 gmask", 32'(gmask_q), 32'h1);
        chk("R10 busy/ack", {busy, ack}, 32'h0);
        rst_n = 1'b1;
        tick();

        for (int k = 0; k < 5; k++) begin
            en = TBL[k][35:20];
            rq = TBL[k][19:4];
            vx = TBL[k][3:0];
            bit1 = 16'(1) << vx;
            en_wr_en = 1'b1; en_wr_data = en;
            flag_clr_en = 1'b1; flag_clr_mask = '1;
            tick();
            en_wr_en = 1'b0; flag_clr_en = 1'b0;
            irq_req = rq;
            tick();
            irq_req = '0;
            chk("R1 flag set", 32'(flag_q), 32'(rq));
            mask_clr = 1'b1;                       // N0
            tick();                                // N1
            mask_clr = 1'b0;
            chk("R4 not yet busy", 32'(busy), 32'h0);
            tick();                                // N2
            chk("R4 busy", 32'(busy), 32'h1);
            tick();                                // N3
            chk("R4 flag cleared", 32'(flag_q), 32'(rq & ~bit1));
            tick();                                // N4
            chk("R3 ack", 32'(ack), 32'h1);
            chk("R3 vector", 32'(vec_idx), 32'(vx));
            tick();                                // N5
            chk("R4 ack single", 32'(ack), 32'h0);
            tick();                                // N6
            chk("R5 idle", 32'(busy), 32'h0);
            chk("R5 gmask", 32'(gmask_q), 32'h1);
            chk("R5 enable", 32'(enable_q), 32'(en & ~bit1));
            ret_req = 1'b1;
            flag_clr_en = 1'b1; flag_clr_mask = '1;
            tick();                                // N7
            ret_req = 1'b0; flag_clr_en = 1'b0;
            chk("R6 enable", 32'(enable_q), 32'(en));
            chk("R6 gmask", 32'(gmask_q), 32'h0);
            mask_set = 1'b1;
            tick();
            mask_set = 1'b0;
        end

        // R2: pending but disabled, mask clear
        en_wr_en = 1'b1; en_wr_data = '0;
        tick();
        en_wr_en = 1'b0;
        irq_req = 16'h0008; mask_clr = 1'b1;
        tick();
        irq_req = '0; mask_clr = 1'b0;
        busy_seen = 0;
        for (int j = 0; j < 6; j++) begin
            tick();
            if (busy) busy_seen++;
        end
        chk("R2 disabled line not taken", 32'(busy_seen), 32'h0);
        chk("R2 flag kept", 32'(flag_q), 32'h0008);
        // R2: enabled but mask set
        mask_set = 1'b1;
        tick();
        mask_set = 1'b0;
        en_wr_en = 1'b1; en_wr_data = 16'h0008;
        tick();
        en_wr_en = 1'b0;
        busy_seen = 0;
        for (int j = 0; j < 6; j++) begin
            tick();
            if (busy) busy_seen++;
        end
        chk("R2 masked not taken", 32'(busy_seen), 32'h0);

        // R8 / R9: writes mid-entry ignored, request on clear edge kept
        mask_clr = 1'b1;                           // N0
        tick();                                    // N1
        mask_clr = 1'b0;
        tick();                                    // N2, state CLEAR
        irq_req = 16'h0008;
        en_wr_en = 1'b1; en_wr_data = 16'hFFFF;
        ret_req = 1'b1; mask_set = 1'b1;
        flag_clr_en = 1'b1; flag_clr_mask = '1;
        tick();                                    // N3
        irq_req = '0; en_wr_en = 1'b0; ret_req = 1'b0;
        mask_set = 1'b0; flag_clr_en = 1'b0;
        chk("R9 flag kept on clear", 32'(flag_q), 32'h0008);
        chk("R8 enable untouched", 32'(enable_q), 32'h0008);
        chk("R8 gmask untouched", 32'(gmask_q), 32'h0);
        tick();                                    // N4
        chk("R3 ack line 3", 32'(vec_idx), 32'h3);
        tick(); tick();                            // N6
        chk("R8 enable after entry", 32'(enable_q), 32'h0000);
        chk("R8 gmask after entry", 32'(gmask_q), 32'h1);

        // R7: nested entry from inside the handler
        en_wr_en = 1'b1; en_wr_data = 16'h0008;
        mask_clr = 1'b1;                           // N0
        tick();
        en_wr_en = 1'b0; mask_clr = 1'b0;
        tick(); tick(); tick();                    // N4
        chk("R7 nested ack", 32'(ack), 32'h1);
        chk("R7 nested vector", 32'(vec_idx), 32'h3);
        tick(); tick();                            // N6
        chk("R7 nested locked", 32'(gmask_q), 32'h1);
        ret_req = 1'b1;
        tick();
        ret_req = 1'b0;
        chk("R7 restored enable", 32'(enable_q), 32'h0008);
        chk("R7 restored gmask", 32'(gmask_q), 32'h0);
        chk("R1 no flags left", 32'(flag_q), 32'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule